// File: doc/BRIEF.md
# FP8 Configuration CSR Write Sequencer

This block turns one FP8 conversion policy into a burst of fixed-format 64-byte control records for a single engine. A start pulse latches the engine type, the policy bits (range extension, saturation mode and two non-OCP conversion flags), the two maximum-exponent words and the DMA-engine count. The block then streams CSR-write records and read-back fence records out as 64-bit beats. A capability input decides whether any programming is allowed at all.

The amount of work depends on the engine type. Every compute engine (types 0 to 3) gets its control register written. Type 3 also gets the exponent-cap register. Type 0 also programs four conversion registers on each DMA engine. Types above 3 need no programming. A fence read of each register window that was touched follows the writes, so that the writes retire before any later traffic.

Top module: `fp8cfg_seq`

## Requirements
- R1: A start taken while `cap_en` is low emits no record, and on the next cycle `cfg_done` and `cfg_err` are both high for one cycle.
- R2: A start taken with `cap_en` high and `eng_type` above 3 emits no record, and on the next cycle `cfg_done` is high with `cfg_err` low.
- R3: For engine types 0 to 3 the first record is a write to address CSR_BASE + CTRL_OFF + type*CTRL_STRIDE (defaults 0x400000, 0x100, 0x40). Its value has range extension in bit 0, saturation in bit 1, flag A in bit 2, flag B in bit 3 and zeros above.
- R4: For type 3 only, the second record is a write to CSR_BASE + EMAX_OFF (default offset 0x200). Its value is {e5m2 cap, e4m3 cap}, with the E4M3 word in bits 15:0 and the E5M2 word in bits 31:16.
- R5: For type 0 only, each DMA engine i, in ascending order from 0 to min(dma_cnt, MAX_DMA)-1, receives four writes in this order: OCP selector 1, OCP selector 0, non-OCP selector 1, non-OCP selector 0. The address is DMA_BASE + i*DMA_STRIDE + (OCP_OFF or NOCP_OFF) + sel*4 (defaults 0x800000, 0x1000, 0x20, 0x30). The OCP value is range extension in bit 0, saturation in bit 1 and sel in bit 4. The non-OCP value is flag A in bit 0, flag B in bit 1, sel in bit 4 and a 1 in bit 5. A count of 0 emits no DMA writes.
- R6: A write record has 0x10A5 in bytes 1:0, 4 in byte 12, the 64-bit address in bytes 23:16, the value in bytes 27:24 and zero in all other bytes. Byte k travels in beat k/8 at bits 8*(k%8)+7 : 8*(k%8).
- R7: After the writes, a fence read of the control register address follows. For type 3 only, a fence read of the exponent-cap address comes last.
- R8: A fence record has 0x10AA in bytes 1:0, 9 in byte 12, the marker 0x80 in byte 13, the address in bytes 23:16 and zero elsewhere.
- R9: Each record is exactly eight beats on a valid/ready stream, with `rec_last` high only on the eighth. While valid is high and ready is low, the beat and the last flag hold steady.
- R10: `start` is ignored while `cfg_busy` is high. The engine type, policy and count are latched when a start is taken, so later input changes do not alter the burst.
- R11: `cfg_done` is a single-cycle pulse. For a burst with records it rises the cycle after the final beat is accepted, and `cfg_err` is low except on an R1 completion. After reset the stream is idle and `cfg_busy` and `cfg_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst when idle |
| cap_en | input | 1 | FP8 conversion capability present |
| eng_type | input | 3 | Engine type to program |
| rng_ext | input | 1 | Range extension policy bit |
| sat_mode | input | 1 | Saturation policy bit |
| nocp_a | input | 1 | First non-OCP conversion flag |
| nocp_b | input | 1 | Second non-OCP conversion flag |
| emax_e4m3 | input | EMAX_W | Maximum exponent cap for E4M3 |
| emax_e5m2 | input | EMAX_W | Maximum exponent cap for E5M2 |
| dma_cnt | input | clog2(MAX_DMA+1) | DMA engines to program for type 0 |
| rec_valid | output | 1 | Record beat valid |
| rec_ready | input | 1 | Downstream accepts the beat |
| rec_data | output | 64 | Record beat, little-endian bytes |
| rec_last | output | 1 | Eighth beat of a record |
| cfg_busy | output | 1 | Burst in progress |
| cfg_done | output | 1 | Burst complete pulse |
| cfg_err | output | 1 | Completion was a capability error |

## Verification
The assertions assume that `rec_ready` is a clean level sampled at the clock edge, and that the checker's own beat count starts from reset with no partial record. The stream is idle in reset, so this holds. They also assume that `eng_type` and `cap_en` are stable across the edge that takes a start. The bench changes every input only just after a falling edge, and raises `start` for one cycle only. The one case that pulses `start` mid-burst, with a different type and capability low, relies on the latch and checks that the burst still matches the original request.

// File: rtl/fp8cfg_pkg.sv
package fp8cfg_pkg;

  localparam int unsigned BEATS    = 8;
  localparam int unsigned BEAT_W   = 64;
  localparam logic [7:0]  OPC_WR   = 8'hA5;
  localparam logic [7:0]  OPC_FNC  = 8'hAA;
  localparam logic [7:0]  REC_LEN  = 8'h10;
  localparam logic [7:0]  WR_BYTES = 8'd4;
  localparam logic [7:0]  FNC_TAG  = 8'd9;
  localparam logic [7:0]  FNC_MARK = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_EMAX, ST_DMA, ST_FCTRL, ST_FEMAX, ST_FIN
  } step_e;

  typedef struct packed {
    logic        is_fence;
    logic [63:0] addr;
    logic [31:0] val;
  } rec_desc_t;

  // engine control register value
  function automatic logic [31:0] ctrl_word(logic rx, logic st, logic fa, logic fb);
    return {28'h0, fb, fa, st, rx};
  endfunction

  // DMA OCP conversion control value
  function automatic logic [31:0] ocp_word(logic rx, logic st, logic sel);
    return {27'h0, sel, 2'b00, st, rx};
  endfunction

  // DMA non-OCP conversion control value
  function automatic logic [31:0] nocp_word(logic fa, logic fb, logic sel);
    return {26'h0, 1'b1, sel, 2'b00, fb, fa};
  endfunction

  // one 64-bit beat of a record, bytes little-endian
  function automatic logic [63:0] rec_beat(rec_desc_t d, int unsigned k);
    logic [63:0] b;
    b = '0;
    case (k)
      0: b = {48'h0, REC_LEN, (d.is_fence ? OPC_FNC : OPC_WR)};
      1: b = {16'h0, (d.is_fence ? FNC_MARK : 8'h00),
              (d.is_fence ? FNC_TAG : WR_BYTES), 32'h0};
      2: b = d.addr;
      3: b = {32'h0, (d.is_fence ? 32'h0 : d.val)};
      default: b = '0;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/fp8cfg_step_fsm.sv
module fp8cfg_step_fsm
  import fp8cfg_pkg::*;
#(
  parameter int          MAX_DMA     = 16,
  parameter int          EMAX_W      = 16,
  parameter logic [63:0] CSR_BASE    = 64'h0040_0000,
  parameter logic [63:0] CTRL_OFF    = 64'h100,
  parameter logic [63:0] CTRL_STRIDE = 64'h40,
  parameter logic [63:0] EMAX_OFF    = 64'h200,
  parameter logic [63:0] DMA_BASE    = 64'h0080_0000,
  parameter logic [63:0] DMA_STRIDE  = 64'h1000,
  parameter logic [63:0] OCP_OFF     = 64'h20,
  parameter logic [63:0] NOCP_OFF    = 64'h30,
  parameter logic [63:0] SEL_STRIDE  = 64'h4,
  localparam int         DCNT_W      = $clog2(MAX_DMA + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cap_en,
  input  logic [2:0]        eng_type,
  input  logic              rng_ext,
  input  logic              sat_mode,
  input  logic              nocp_a,
  input  logic              nocp_b,
  input  logic [EMAX_W-1:0] emax_e4m3,
  input  logic [EMAX_W-1:0] emax_e5m2,
  input  logic [DCNT_W-1:0] dma_cnt,
  input  logic              rec_done,
  output step_e             step,
  output rec_desc_t         desc,
  output logic              rec_active,
  output logic              start_take,
  output logic              fin_err
);

  localparam logic [DCNT_W-1:0] CNT_CAP = DCNT_W'(MAX_DMA);

  step_e             step_q, nxt_step;
  logic [2:0]        ty_q;
  logic              rx_q, st_q, fa_q, fb_q, err_q;
  logic [EMAX_W-1:0] e4_q, e5_q;
  logic [DCNT_W-1:0] cnt_q, idx_q, nxt_idx;
  logic [1:0]        sub_q, nxt_sub;

  function automatic logic [31:0] emax_word(logic [EMAX_W-1:0] a, logic [EMAX_W-1:0] b);
    return 32'({b, a});
  endfunction

  function automatic logic [63:0] dma_addr(logic [DCNT_W-1:0] i, logic [1:0] s);
    logic [63:0] base;
    base = DMA_BASE + 64'(i) * DMA_STRIDE;
    base = base + (s[1] ? NOCP_OFF : OCP_OFF);
    return base + (s[0] ? 64'h0 : SEL_STRIDE);
  endfunction

  assign start_take = (step_q == ST_IDLE) && start;
  assign step       = step_q;
  assign fin_err    = (step_q == ST_FIN) && err_q;
  assign rec_active = (step_q != ST_IDLE) && (step_q != ST_FIN);

  logic [63:0] ctrl_addr, emax_addr;
  assign ctrl_addr = CSR_BASE + CTRL_OFF + 64'(ty_q) * CTRL_STRIDE;
  assign emax_addr = CSR_BASE + EMAX_OFF;

  always_comb begin
    desc = '0;
    case (step_q)
      ST_CTRL: begin
        desc.addr = ctrl_addr;
        desc.val  = ctrl_word(rx_q, st_q, fa_q, fb_q);
      end
      ST_EMAX: begin
        desc.addr = emax_addr;
        desc.val  = emax_word(e4_q, e5_q);
      end
      ST_DMA: begin
        desc.addr = dma_addr(idx_q, sub_q);
        desc.val  = sub_q[1] ? nocp_word(fa_q, fb_q, ~sub_q[0])
                             : ocp_word(rx_q, st_q, ~sub_q[0]);
      end
      ST_FCTRL: begin
        desc.is_fence = 1'b1;
        desc.addr     = ctrl_addr;
      end
      ST_FEMAX: begin
        desc.is_fence = 1'b1;
        desc.addr     = emax_addr;
      end
      default: desc = '0;
    endcase
  end

  always_comb begin
    nxt_step = step_q;
    nxt_idx  = idx_q;
    nxt_sub  = sub_q;
    case (step_q)
      ST_CTRL: begin
        if (ty_q == 3'd3)
          nxt_step = ST_EMAX;
        else if (ty_q == 3'd0 && cnt_q != '0) begin
          nxt_step = ST_DMA;
          nxt_idx  = '0;
          nxt_sub  = 2'd0;
        end else
          nxt_step = ST_FCTRL;
      end
      ST_EMAX: nxt_step = ST_FCTRL;
      ST_DMA: begin
        if (sub_q != 2'd3)
          nxt_sub = sub_q + 2'd1;
        else if (idx_q != DCNT_W'(cnt_q - 1'b1)) begin
          nxt_sub = 2'd0;
          nxt_idx = idx_q + 1'b1;
        end else
          nxt_step = ST_FCTRL;
      end
      ST_FCTRL: nxt_step = (ty_q == 3'd3) ? ST_FEMAX : ST_FIN;
      ST_FEMAX: nxt_step = ST_FIN;
      default:  nxt_step = step_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_IDLE;
      ty_q   <= '0;
      rx_q   <= 1'b0;
      st_q   <= 1'b0;
      fa_q   <= 1'b0;
      fb_q   <= 1'b0;
      e4_q   <= '0;
      e5_q   <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sub_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      case (step_q)
        ST_IDLE: begin
          if (start) begin
            ty_q  <= eng_type;
            rx_q  <= rng_ext;
            st_q  <= sat_mode;
            fa_q  <= nocp_a;
            fb_q  <= nocp_b;
            e4_q  <= emax_e4m3;
            e5_q  <= emax_e5m2;
            cnt_q <= (dma_cnt > CNT_CAP) ? CNT_CAP : dma_cnt;
            idx_q <= '0;
            sub_q <= '0;
            err_q <= ~cap_en;
            if (!cap_en || eng_type > 3'd3)
              step_q <= ST_FIN;
            else
              step_q <= ST_CTRL;
          end
        end
        ST_FIN: step_q <= ST_IDLE;
        default: begin
          if (rec_done) begin
            step_q <= nxt_step;
            idx_q  <= nxt_idx;
            sub_q  <= nxt_sub;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/fp8cfg_rec_build.sv
module fp8cfg_rec_build
  import fp8cfg_pkg::*;
(
  input  rec_desc_t   desc,
  input  logic [2:0]  beat_idx,
  output logic [63:0] beat_data
);

  logic [BEAT_W-1:0] beats [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    assign beats[g] = rec_beat(desc, g);
  end

  assign beat_data = beats[beat_idx];

endmodule

// File: rtl/fp8cfg_beat_tx.sv
module fp8cfg_beat_tx
  import fp8cfg_pkg::*;
#(
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             rec_ready,
  output logic             rec_valid,
  output logic             rec_last,
  output logic [IDX_W-1:0] beat_idx,
  output logic             rec_done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BEATS - 1);

  logic [IDX_W-1:0] beat_q;
  logic             accept;

  assign rec_valid = active;
  assign rec_last  = active && (beat_q == LAST_IDX);
  assign accept    = rec_valid && rec_ready;
  assign rec_done  = accept && (beat_q == LAST_IDX);
  assign beat_idx  = beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      beat_q <= '0;
    else if (rec_done)
      beat_q <= '0;
    else if (accept)
      beat_q <= beat_q + 1'b1;
  end

endmodule

// File: rtl/fp8cfg_seq.sv
module fp8cfg_seq
  import fp8cfg_pkg::*;
#(
  parameter int          MAX_DMA     = 16,
  parameter int          EMAX_W      = 16,
  parameter logic [63:0] CSR_BASE    = 64'h0040_0000,
  parameter logic [63:0] CTRL_OFF    = 64'h100,
  parameter logic [63:0] CTRL_STRIDE = 64'h40,
  parameter logic [63:0] EMAX_OFF    = 64'h200,
  parameter logic [63:0] DMA_BASE    = 64'h0080_0000,
  parameter logic [63:0] DMA_STRIDE  = 64'h1000,
  parameter logic [63:0] OCP_OFF     = 64'h20,
  parameter logic [63:0] NOCP_OFF    = 64'h30,
  parameter logic [63:0] SEL_STRIDE  = 64'h4,
  localparam int         DCNT_W      = $clog2(MAX_DMA + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cap_en,
  input  logic [2:0]        eng_type,
  input  logic              rng_ext,
  input  logic              sat_mode,
  input  logic              nocp_a,
  input  logic              nocp_b,
  input  logic [EMAX_W-1:0] emax_e4m3,
  input  logic [EMAX_W-1:0] emax_e5m2,
  input  logic [DCNT_W-1:0] dma_cnt,
  output logic              rec_valid,
  input  logic              rec_ready,
  output logic [63:0]       rec_data,
  output logic              rec_last,
  output logic              cfg_busy,
  output logic              cfg_done,
  output logic              cfg_err
);

  step_e     step;
  rec_desc_t desc;
  logic      rec_active;
  logic      start_take;
  logic      fin_err;
  logic      rec_accept;
  logic [2:0] beat_idx;

  fp8cfg_step_fsm #(
    .MAX_DMA(MAX_DMA), .EMAX_W(EMAX_W), .CSR_BASE(CSR_BASE),
    .CTRL_OFF(CTRL_OFF), .CTRL_STRIDE(CTRL_STRIDE), .EMAX_OFF(EMAX_OFF),
    .DMA_BASE(DMA_BASE), .DMA_STRIDE(DMA_STRIDE), .OCP_OFF(OCP_OFF),
    .NOCP_OFF(NOCP_OFF), .SEL_STRIDE(SEL_STRIDE)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_en(cap_en),
    .eng_type(eng_type), .rng_ext(rng_ext), .sat_mode(sat_mode),
    .nocp_a(nocp_a), .nocp_b(nocp_b), .emax_e4m3(emax_e4m3),
    .emax_e5m2(emax_e5m2), .dma_cnt(dma_cnt), .rec_done(rec_accept),
    .step(step), .desc(desc), .rec_active(rec_active),
    .start_take(start_take), .fin_err(fin_err)
  );

  fp8cfg_beat_tx tx_i (
    .clk(clk), .rst_n(rst_n), .active(rec_active), .rec_ready(rec_ready),
    .rec_valid(rec_valid), .rec_last(rec_last), .beat_idx(beat_idx),
    .rec_done(rec_accept)
  );

  fp8cfg_rec_build build_i (
    .desc(desc), .beat_idx(beat_idx), .beat_data(rec_data)
  );

  assign cfg_busy = (step != ST_IDLE);
  assign cfg_done = (step == ST_FIN);
  assign cfg_err  = fin_err;

endmodule

// File: rtl/fp8cfg_seq_chk.sv
module fp8cfg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cap_en,
  input logic [2:0]  eng_type,
  input logic        rec_valid,
  input logic        rec_ready,
  input logic [63:0] rec_data,
  input logic        rec_last,
  input logic        cfg_busy,
  input logic        cfg_done,
  input logic        cfg_err,
  input logic        start_take,
  input logic        rec_accept
);

  logic [2:0] seen_beats;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      seen_beats <= '0;
    else if (rec_valid && rec_ready)
      seen_beats <= seen_beats + 3'd1;
  end

  // R1
  cap_low_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_take && !cap_en |=> cfg_done && cfg_err && !rec_valid);

  // R2
  high_type_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_take && cap_en && (eng_type > 3'd3) |=> cfg_done && !cfg_err && !rec_valid);

  // R6
  rec_head_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && (seen_beats == 3'd0) |->
      (rec_data[15:0] == 16'h10A5) || (rec_data[15:0] == 16'h10AA));

  // R9
  beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_data) && $stable(rec_last));

  // R9
  last_on_eighth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_last == (seen_beats == 3'd7)));

  // R10
  busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_busy) |-> $past(start));

  // R10
  stream_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> cfg_busy);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |=> !cfg_done);

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done |-> !rec_valid && (seen_beats == 3'd0));

  // R11
  accept_then_more_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_accept |=> rec_valid || cfg_done);

endmodule

bind fp8cfg_seq fp8cfg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .cap_en(cap_en),
  .eng_type(eng_type), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_data(rec_data), .rec_last(rec_last), .cfg_busy(cfg_busy),
  .cfg_done(cfg_done), .cfg_err(cfg_err), .start_take(start_take),
  .rec_accept(rec_accept)
);

// File: tb/fp8cfg_seq_tb_top.sv
`timescale 1ns/1ps
module fp8cfg_seq_tb_top;

  localparam int MAXD = 4;
  localparam logic [63:0] T_CSR  = 64'h0040_0000;
  localparam logic [63:0] T_CTRL = 64'h100;
  localparam logic [63:0] T_CSTR = 64'h40;
  localparam logic [63:0] T_EMAX = 64'h200;
  localparam logic [63:0] T_DMA  = 64'h0080_0000;
  localparam logic [63:0] T_DSTR = 64'h1000;
  localparam logic [63:0] T_OCP  = 64'h20;
  localparam logic [63:0] T_NOCP = 64'h30;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, cap_en, rng_ext, sat_mode, nocp_a, nocp_b;
  logic [2:0]  eng_type;
  logic [15:0] emax_e4m3, emax_e5m2;
  logic [2:0]  dma_cnt;
  logic        rec_valid, rec_ready, rec_last;
  logic [63:0] rec_data;
  logic        cfg_busy, cfg_done, cfg_err;

  always #2 clk = ~clk;

  fp8cfg_seq #(.MAX_DMA(MAXD)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cap_en(cap_en),
    .eng_type(eng_type), .rng_ext(rng_ext), .sat_mode(sat_mode),
    .nocp_a(nocp_a), .nocp_b(nocp_b), .emax_e4m3(emax_e4m3),
    .emax_e5m2(emax_e5m2), .dma_cnt(dma_cnt), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_data(rec_data), .rec_last(rec_last),
    .cfg_busy(cfg_busy), .cfg_done(cfg_done), .cfg_err(cfg_err)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rdy_mode = 0;
  int rec_n, beat_n, done_cnt, done_cyc, last_acc_cyc, last_bad;
  logic done_err;
  logic [63:0] cap_b [0:31][0:7];

  bit          exp_f [0:31];
  logic [63:0] exp_a [0:31];
  logic [31:0] exp_v [0:31];
  string       exp_t [0:31];
  int          exp_n;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic add_exp(bit f, logic [63:0] a, logic [31:0] v, string t);
    exp_f[exp_n] = f;
    exp_a[exp_n] = a;
    exp_v[exp_n] = v;
    exp_t[exp_n] = t;
    exp_n++;
  endtask

  function automatic logic [63:0] exp_beat(bit f, logic [63:0] a, logic [31:0] v, int k);
    if (k == 0) return f ? 64'h10AA : 64'h10A5;
    if (k == 1) return f ? ((64'h80 << 40) | (64'h9 << 32)) : (64'h4 << 32);
    if (k == 2) return a;
    if (k == 3) return f ? 64'h0 : {32'h0, v};
    return 64'h0;
  endfunction

  // stream monitor and ready driver
  initial begin
    rec_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      case (rdy_mode)
        0: rec_ready = 1'b1;
        1: rec_ready = (cyc % 3) != 0;
        default: rec_ready = (cyc % 2) == 0;
      endcase
      if (rst_n && rec_valid && rec_ready) begin
        if (rec_n < 32) cap_b[rec_n][beat_n] = rec_data;
        if (rec_last != (beat_n == 7)) last_bad++;
        beat_n++;
        if (beat_n == 8) begin
          beat_n = 0;
          rec_n++;
          last_acc_cyc = cyc;
        end
      end
      if (rst_n && cfg_done) begin
        done_cnt++;
        done_cyc = cyc;
        done_err = cfg_err;
      end
    end
  end

  task automatic run_case(int ty, bit cap, bit rx, bit st, bit fa, bit fb,
                          logic [15:0] e4, logic [15:0] e5, int cnt, bit mid);
    int start_cyc;
    int w;
    int ce;
    exp_n = 0;
    if (cap && ty <= 3) begin
      add_exp(0, T_CSR + T_CTRL + 64'(ty) * T_CSTR,
              {28'h0, fb, fa, st, rx}, "R3");
      if (ty == 3)
        add_exp(0, T_CSR + T_EMAX, {e5, e4}, "R4");
      if (ty == 0) begin
        ce = (cnt > MAXD) ? MAXD : cnt;
        for (int i = 0; i < ce; i++) begin
          for (int s = 1; s >= 0; s--)
            add_exp(0, T_DMA + 64'(i) * T_DSTR + T_OCP + 64'(s) * 4,
                    32'(rx) + 32'(st) * 2 + 32'(s) * 16, "R5");
          for (int s = 1; s >= 0; s--)
            add_exp(0, T_DMA + 64'(i) * T_DSTR + T_NOCP + 64'(s) * 4,
                    32'(fa) + 32'(fb) * 2 + 32'(s) * 16 + 32, "R5");
        end
      end
      add_exp(1, T_CSR + T_CTRL + 64'(ty) * T_CSTR, 32'h0, "R7");
      if (ty == 3)
        add_exp(1, T_CSR + T_EMAX, 32'h0, "R7");
    end

    @(negedge clk); #1;
    rec_n = 0; beat_n = 0; done_cnt = 0; done_cyc = 0;
    last_acc_cyc = 0; last_bad = 0; done_err = 1'b0;
    eng_type = 3'(ty); cap_en = cap; rng_ext = rx; sat_mode = st;
    nocp_a = fa; nocp_b = fb; emax_e4m3 = e4; emax_e5m2 = e5;
    dma_cnt = 3'(cnt);
    start = 1'b1;
    start_cyc = cyc;
    @(negedge clk); #1;
    start = 1'b0;
    if (mid) begin
      repeat (4) begin @(negedge clk); #1; end
      start = 1'b1; eng_type = 3'd3; cap_en = 1'b0; rng_ext = ~rx;
      dma_cnt = 3'd1; emax_e4m3 = ~e4;
      @(negedge clk); #1;
      start = 1'b0;
    end
    w = 0;
    while (done_cnt == 0 && w < 3000) begin
      @(negedge clk); #1;
      w++;
    end
    @(negedge clk); #1;

    chk(done_cnt == 1, "R11", "done pulse count", 64'(done_cnt), 64'd1);
    chk(done_err == !cap, cap ? "R11" : "R1", "error flag",
        64'(done_err), 64'(!cap));
    chk(rec_n == exp_n, (ty > 3) ? "R2" : (cap ? "R5" : "R1"),
        "record count", 64'(rec_n), 64'(exp_n));
    if (exp_n == 0)
      chk(done_cyc == start_cyc + 1, cap ? "R2" : "R1", "done timing",
          64'(done_cyc), 64'(start_cyc + 1));
    else
      chk(done_cyc == last_acc_cyc + 1, "R11", "done after last accept",
          64'(done_cyc), 64'(last_acc_cyc + 1));
    chk(last_bad == 0, "R9", "last flag misplaced", 64'(last_bad), 64'd0);
    chk(!cfg_busy, "R10", "busy after done", 64'(cfg_busy), 64'd0);
    for (int r = 0; r < exp_n && r < rec_n; r++) begin
      for (int k = 0; k < 8; k++) begin
        logic [63:0] e;
        e = exp_beat(exp_f[r], exp_a[r], exp_v[r], k);
        if (k < 2)
          chk(cap_b[r][k] == e, exp_f[r] ? "R8" : "R6", "record header",
              cap_b[r][k], e);
        else
          chk(cap_b[r][k] == e, mid ? "R10" : exp_t[r], "record body",
              cap_b[r][k], e);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cap_en = 1'b0; eng_type = 3'd0;
    rng_ext = 1'b0; sat_mode = 1'b0; nocp_a = 1'b0; nocp_b = 1'b0;
    emax_e4m3 = '0; emax_e5m2 = '0; dma_cnt = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!rec_valid && !cfg_busy && !cfg_done, "R11", "reset state",
        {61'h0, rec_valid, cfg_busy, cfg_done}, 64'h0);
    rst_n = 1'b1;

    for (int ty = 0; ty < 8; ty++)
      run_case(ty, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'h11, 16'h22, 2, 1'b0);
    for (int ty = 4; ty < 8; ty++)
      for (int f = 0; f < 2; f++)
        run_case(ty, 1'b1, f[0], 1'b1, 1'b0, f[0], 16'h5, 16'h6, 3, 1'b0);
    for (int ty = 1; ty < 4; ty++)
      for (int f = 0; f < 16; f++) begin
        rdy_mode = f % 3;
        run_case(ty, 1'b1, f[0], f[1], f[2], f[3],
                 16'(16'h0100 + f * 3), 16'(16'h2000 + ty * 17 + f), 0, 1'b0);
      end
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 16; f++) begin
        rdy_mode = (f + c) % 3;
        run_case(0, 1'b1, f[0], f[1], f[2], f[3], 16'h7, 16'h9, c, 1'b0);
      end
    rdy_mode = 1;
    run_case(0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h3, 16'h4, 2, 1'b1);
    run_case(3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hBEEF, 16'hCAFE, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule